// File: doc/BRIEF.md
# Programmable PHY Header Length Extractor

This block sits on the receive side of a packet format that is defined by the user. Serial bits of the PHY frame arrive one per accepted cycle after a frame-start pulse. The first one or two octets are the PHY header. Inside that header a length field is picked out at a run-time bit offset, with a run-time width and either bit order. The length is reported on its own pulse. It then sets where the frame ends and which bits are passed on to a downstream CRC engine.

A length that would push the frame past the maximum frame size raises an error. In that case the frame is cut off after its header. A window that does not fit inside the header raises a configuration error, and no length is produced.

On the transmit side, a small generator can put a one-octet length header in front of the buffered bit stream, sent least significant bit first. When that option is off, every bit comes straight from the transmit buffer.

Top module: `phl_hdr_extract`

## Requirements
- R1: After reset, len_valid, len_value, crc_valid, frame_end, oversize_error and tx_buf_pop are all 0.
- R2: Bit position 0 is the first bit accepted after rx_start. The field occupies positions cfg_len_offset to cfg_len_offset+cfg_len_width-1. With cfg_len_msb_first=1 the first arriving field bit is the value's most significant bit; with 0 it is bit 0. len_valid pulses for one cycle, in the cycle after the last field bit is accepted. len_value shows the value from that cycle on and holds it while no bits are accepted.
- R3: cfg_error is high whenever cfg_len_width is 0 or above 9, cfg_len_offset is above 12, or offset+width exceeds the header bit count. With cfg_error high, no len_valid and no frame_end are produced.
- R4: cfg_two_octet=0 gives an 8-bit header; cfg_two_octet=1 gives a 16-bit header.
- R5: Each accepted bit at positions 0 to header_bits+8*length-1 is forwarded on crc_bit, with crc_valid high, one cycle after it is accepted. No later bit is forwarded. On a configuration error or an oversize frame, only the header bits are forwarded.
- R6: frame_end pulses together with the crc_valid of the last forwarded bit. A length of 0 ends the frame at the last header bit, which is the same cycle as len_valid when the field ends on that bit.
- R7: When header octets plus length exceed 511, oversize_error pulses in the same cycle as len_valid and no frame_end follows.
- R8: Cycles with rx_valid low advance nothing. An rx_start in the middle of a frame abandons that frame and begins a new one at position 0.
- R9: A tx_start with tx_auto_hdr=1 makes the next 8 tx_step cycles drive the bits of tx_len on tx_bit, LSB first, with tx_buf_pop low. After that, tx_bit equals tx_buf_bit and tx_buf_pop equals tx_step.
- R10: With tx_auto_hdr=0 at tx_start, tx_bit equals tx_buf_bit and tx_buf_pop follows tx_step from the next cycle on. A tx_step in the tx_start cycle does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Marks the start of a received PHY frame |
| rx_valid | input | 1 | rx_bit carries a frame bit this cycle |
| rx_bit | input | 1 | Received serial bit |
| cfg_two_octet | input | 1 | Header is two octets when set, one otherwise |
| cfg_len_offset | input | 4 | Bit position where the length field starts |
| cfg_len_width | input | 4 | Length field width in bits |
| cfg_len_msb_first | input | 1 | Field arrives most significant bit first |
| len_valid | output | 1 | One-cycle pulse: length field complete |
| len_value | output | 9 | Extracted length in octets after the header |
| cfg_error | output | 1 | Field window is illegal |
| oversize_error | output | 1 | Pulse: frame would exceed 511 octets |
| crc_valid | output | 1 | crc_bit is a bit inside the CRC span |
| crc_bit | output | 1 | Forwarded frame bit |
| frame_end | output | 1 | Pulse with the last forwarded bit |
| tx_start | input | 1 | Start of a transmit frame |
| tx_auto_hdr | input | 1 | Insert an automatic one-octet length header |
| tx_len | input | 8 | Length value for the automatic header |
| tx_step | input | 1 | Serializer consumes one bit this cycle |
| tx_buf_bit | input | 1 | Next bit from the transmit buffer |
| tx_bit | output | 1 | Outgoing serial bit |
| tx_buf_pop | output | 1 | Transmit buffer bit consumed |

## Verification
The length report and the end of the frame land in the same cycle when the length is zero and the field's last bit is also the header's last bit. The sweep over offset, width, order and header size forces this case for every such window, and the bench computes whether len_valid and frame_end should coincide. A second overlap is a new rx_start arriving while a frame is still in progress. It is provoked by cutting a frame short, inside and past its field, and starting the next one in the following cycle. That next frame is then judged bit for bit against its own expected span.

// File: rtl/phl_pkg.sv
package phl_pkg;

    localparam int LEN_W         = 9;
    localparam int CFG_W         = 4;
    localparam int OFF_MAX       = 12;
    localparam int OCT_BITS      = 8;
    localparam int HDR_MAX_OCT   = 2;
    localparam int FRAME_MAX_OCT = 511;
    localparam int POS_W = $clog2(HDR_MAX_OCT * OCT_BITS + FRAME_MAX_OCT * OCT_BITS + 1);

    typedef logic [LEN_W-1:0] len_t;
    typedef logic [POS_W-1:0] pos_t;
    typedef logic [CFG_W-1:0] cfgf_t;

    typedef struct packed {
        logic  two_oct;
        cfgf_t offset;
        cfgf_t width;
        logic  msb_first;
    } fld_cfg_t;

    typedef struct packed {
        logic ok;
        pos_t first;
        pos_t last;
        pos_t hdr_last;
    } fld_win_t;

    function automatic pos_t hdr_bits(input logic two);
        return two ? pos_t'(2 * OCT_BITS) : pos_t'(OCT_BITS);
    endfunction

    function automatic fld_win_t field_window(input fld_cfg_t c);
        fld_win_t w;
        pos_t     hb;
        hb         = hdr_bits(c.two_oct);
        w.first    = pos_t'(c.offset);
        w.last     = pos_t'(c.offset) + pos_t'(c.width) - pos_t'(1);
        w.hdr_last = hb - pos_t'(1);
        w.ok       = (c.width != '0) && (int'(c.width) <= LEN_W)
                  && (int'(c.offset) <= OFF_MAX)
                  && ((pos_t'(c.offset) + pos_t'(c.width)) <= hb);
        return w;
    endfunction

    function automatic pos_t span_last(input pos_t hdr_last, input len_t len);
        return hdr_last + pos_t'(len) * pos_t'(OCT_BITS);
    endfunction

endpackage

// File: rtl/phl_field_capture.sv
module phl_field_capture
    import phl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic     bit_in,
    input  pos_t     pos,
    input  fld_win_t win,
    input  logic     msb_first,
    output logic     last_now,
    output len_t     len_now,
    output len_t     len_q,
    output logic     len_vld
);

    logic in_field;
    len_t base;
    pos_t k;

    always_comb begin
        in_field = take && win.ok && (pos >= win.first) && (pos <= win.last);
        last_now = in_field && (pos == win.last);
        base     = (pos == win.first) ? '0 : len_q;
        k        = pos - win.first;
        if (msb_first)
            len_now = {base[LEN_W-2:0], bit_in};
        else
            len_now = base | (len_t'(bit_in) << k);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            len_vld <= 1'b0;
        end else begin
            len_vld <= last_now;
            if (in_field)
                len_q <= len_now;
        end
    end

endmodule

// File: rtl/phl_frame_tracker.sv
module phl_frame_tracker
    import phl_pkg::*;
#(
    parameter int MAX_FRAME_OCT = FRAME_MAX_OCT
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     bit_vld,
    input  logic     bit_in,
    input  fld_win_t win,
    input  logic     two_oct,
    input  logic     field_last,
    input  len_t     len_now,
    output pos_t     pos_eff,
    output logic     take,
    output logic     crc_vld,
    output logic     crc_bit,
    output logic     frame_end,
    output logic     oversize
);

    localparam int HDR_OCT_1 = 1;
    localparam int HDR_OCT_2 = HDR_MAX_OCT;

    logic active_q, have_q, abort_q;
    pos_t pos_q, end_q;

    logic active_eff, have_now, abort_now, over_now, live;
    logic covered, last_bit, stop;
    pos_t end_now;

    always_comb begin
        active_eff = start | active_q;
        pos_eff    = start ? '0 : pos_q;
        take       = bit_vld && active_eff;
        over_now   = field_last &&
                     ((int'(len_now) + (two_oct ? HDR_OCT_2 : HDR_OCT_1)) > MAX_FRAME_OCT);
        have_now   = (!start && have_q) || field_last;
        abort_now  = (!start && abort_q) || over_now;
        end_now    = field_last ? span_last(win.hdr_last, len_now) : end_q;
        live       = have_now && !abort_now;
        covered    = take && ((pos_eff <= win.hdr_last) || (live && (pos_eff <= end_now)));
        last_bit   = take && live && (pos_eff == end_now);
        stop       = last_bit || (take && !live && (pos_eff == win.hdr_last));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            have_q    <= 1'b0;
            abort_q   <= 1'b0;
            pos_q     <= '0;
            end_q     <= '0;
            crc_vld   <= 1'b0;
            crc_bit   <= 1'b0;
            frame_end <= 1'b0;
            oversize  <= 1'b0;
        end else begin
            active_q  <= active_eff && !stop;
            pos_q     <= take ? pos_eff + pos_t'(1) : pos_eff;
            have_q    <= have_now;
            abort_q   <= abort_now;
            end_q     <= end_now;
            crc_vld   <= covered;
            crc_bit   <= bit_in;
            frame_end <= last_bit;
            oversize  <= over_now;
        end
    end

endmodule

// File: rtl/phl_tx_hdr_gen.sv
module phl_tx_hdr_gen
    import phl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_start,
    input  logic                auto_en,
    input  logic [OCT_BITS-1:0] hdr_len,
    input  logic                step,
    input  logic                buf_bit,
    output logic                bit_out,
    output logic                buf_pop
);

    localparam int CNT_W = $clog2(OCT_BITS + 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [OCT_BITS-1:0] sh_q;
    logic                hdr_act;

    always_comb begin
        hdr_act = (cnt_q != '0);
        bit_out = hdr_act ? sh_q[0] : buf_bit;
        buf_pop = step && !tx_start && !hdr_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (tx_start) begin
            cnt_q <= auto_en ? CNT_W'(OCT_BITS) : '0;
            sh_q  <= hdr_len;
        end else if (step && hdr_act) begin
            cnt_q <= cnt_q - CNT_W'(1);
            sh_q  <= sh_q >> 1;
        end
    end

endmodule

// File: rtl/phl_hdr_extract.sv
module phl_hdr_extract
    import phl_pkg::*;
#(
    parameter int MAX_FRAME_OCT = FRAME_MAX_OCT
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             cfg_two_octet,
    input  logic [CFG_W-1:0] cfg_len_offset,
    input  logic [CFG_W-1:0] cfg_len_width,
    input  logic             cfg_len_msb_first,
    output logic             len_valid,
    output logic [LEN_W-1:0] len_value,
    output logic             cfg_error,
    output logic             oversize_error,
    output logic             crc_valid,
    output logic             crc_bit,
    output logic             frame_end,
    input  logic             tx_start,
    input  logic             tx_auto_hdr,
    input  logic [7:0]       tx_len,
    input  logic             tx_step,
    input  logic             tx_buf_bit,
    output logic             tx_bit,
    output logic             tx_buf_pop
);

    fld_cfg_t cfg;
    fld_win_t win;
    pos_t     pos_eff;
    logic     take, field_last;
    len_t     len_now;

    always_comb begin
        cfg.two_oct   = cfg_two_octet;
        cfg.offset    = cfg_len_offset;
        cfg.width     = cfg_len_width;
        cfg.msb_first = cfg_len_msb_first;
        win           = field_window(cfg);
        cfg_error     = !win.ok;
    end

    phl_field_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .bit_in    (rx_bit),
        .pos       (pos_eff),
        .win       (win),
        .msb_first (cfg_len_msb_first),
        .last_now  (field_last),
        .len_now   (len_now),
        .len_q     (len_value),
        .len_vld   (len_valid)
    );

    phl_frame_tracker #(.MAX_FRAME_OCT(MAX_FRAME_OCT)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .start      (rx_start),
        .bit_vld    (rx_valid),
        .bit_in     (rx_bit),
        .win        (win),
        .two_oct    (cfg_two_octet),
        .field_last (field_last),
        .len_now    (len_now),
        .pos_eff    (pos_eff),
        .take       (take),
        .crc_vld    (crc_valid),
        .crc_bit    (crc_bit),
        .frame_end  (frame_end),
        .oversize   (oversize_error)
    );

    phl_tx_hdr_gen u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_start (tx_start),
        .auto_en  (tx_auto_hdr),
        .hdr_len  (tx_len),
        .step     (tx_step),
        .buf_bit  (tx_buf_bit),
        .bit_out  (tx_bit),
        .buf_pop  (tx_buf_pop)
    );

endmodule

// File: rtl/phl_hdr_extract_chk.sv
module phl_hdr_extract_chk
    import phl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_start,
    input logic             rx_valid,
    input logic             len_valid,
    input logic [LEN_W-1:0] len_value,
    input logic             cfg_error,
    input logic             oversize_error,
    input logic             crc_valid,
    input logic             frame_end,
    input logic             tx_start,
    input logic             tx_auto_hdr,
    input logic             tx_buf_pop
);

    // R3: a bad window never yields a length
    p_err_blocks_len_r3: assert property (@(posedge clk) disable iff (rst)
        len_valid |-> !$past(cfg_error));

    // R6: end of frame always rides on a forwarded bit
    p_end_with_crc_r6: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> crc_valid);

    // R7: oversize is reported alongside the length
    p_over_with_len_r7: assert property (@(posedge clk) disable iff (rst)
        oversize_error |-> len_valid);

    // R7: oversize never ends the frame normally
    p_over_no_end_r7: assert property (@(posedge clk) disable iff (rst)
        oversize_error |-> !frame_end);

    // R5: forwarded bits come only from accepted input bits
    p_crc_needs_bit_r5: assert property (@(posedge clk) disable iff (rst)
        crc_valid |-> $past(rx_valid));

    // R2: the length holds while no bits are accepted
    p_len_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_valid) |-> $stable(len_value));

    // R8: a fresh frame cannot end right after its start
    p_start_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rx_start) |-> !frame_end);

    // R9: automatic header blocks the buffer right after start
    p_auto_hdr_no_pop_r9: assert property (@(posedge clk) disable iff (rst)
        $past(tx_start && tx_auto_hdr) |-> !tx_buf_pop);

endmodule

bind phl_hdr_extract phl_hdr_extract_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .rx_start       (rx_start),
    .rx_valid       (rx_valid),
    .len_valid      (len_valid),
    .len_value      (len_value),
    .cfg_error      (cfg_error),
    .oversize_error (oversize_error),
    .crc_valid      (crc_valid),
    .frame_end      (frame_end),
    .tx_start       (tx_start),
    .tx_auto_hdr    (tx_auto_hdr),
    .tx_buf_pop     (tx_buf_pop)
);

// File: tb/phl_hdr_extract_tb_top.sv
module phl_hdr_extract_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_start, rx_valid, rx_bit;
    logic       cfg_two_octet, cfg_len_msb_first;
    logic [3:0] cfg_len_offset, cfg_len_width;
    logic       len_valid, cfg_error, oversize_error, crc_valid, crc_bit, frame_end;
    logic [8:0] len_value;
    logic       tx_start, tx_auto_hdr, tx_step, tx_buf_bit, tx_bit, tx_buf_pop;
    logic [7:0] tx_len;

    always #5 clk = ~clk;

    phl_hdr_extract dut_i (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .cfg_two_octet(cfg_two_octet), .cfg_len_offset(cfg_len_offset),
        .cfg_len_width(cfg_len_width), .cfg_len_msb_first(cfg_len_msb_first),
        .len_valid(len_valid), .len_value(len_value), .cfg_error(cfg_error),
        .oversize_error(oversize_error), .crc_valid(crc_valid), .crc_bit(crc_bit),
        .frame_end(frame_end), .tx_start(tx_start), .tx_auto_hdr(tx_auto_hdr),
        .tx_len(tx_len), .tx_step(tx_step), .tx_buf_bit(tx_buf_bit),
        .tx_bit(tx_bit), .tx_buf_pop(tx_buf_pop)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    bit exp_bits [0:4199];
    int o_crc_cnt, o_crc_bad, o_fe_cnt, o_fe_at, o_lv_cnt, o_lv_val, o_ov_cnt;
    bit o_same;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic observe();
        if (crc_valid) begin
            if (o_crc_cnt < 4200 && crc_bit !== exp_bits[o_crc_cnt]) o_crc_bad++;
            o_crc_cnt++;
        end
        if (frame_end) begin
            o_fe_cnt++;
            o_fe_at = o_crc_cnt;
        end
        if (len_valid) begin
            o_lv_cnt++;
            o_lv_val = int'(len_value);
            if (frame_end) o_same = 1'b1;
        end
        if (oversize_error) o_ov_cnt++;
    endtask

    task automatic rx_frame(input int two, input int off, input int wid, input int msb,
                            input int len, input int extra, input int gaps);
        int hb, fv, span, n;
        bit ok, over, same;
        hb   = two ? 16 : 8;
        ok   = (wid >= 1) && (wid <= 9) && (off <= 12) && (off + wid <= hb);
        over = ok && ((hb / 8) + len > 511);
        fv   = ok ? (len & ((1 << wid) - 1)) : 0;
        span = (ok && !over) ? hb + 8 * len : hb;
        same = ok && !over && (fv == 0) && (off + wid == hb);
        n    = span + extra;
        for (int i = 0; i < n; i++) exp_bits[i] = ((i * 5 + two + off) % 7) < 3;
        if (ok)
            for (int k = 0; k < wid; k++)
                exp_bits[off + k] = msb ? ((fv >> (wid - 1 - k)) & 1) : ((fv >> k) & 1);
        o_crc_cnt = 0; o_crc_bad = 0; o_fe_cnt = 0; o_fe_at = -1;
        o_lv_cnt = 0; o_lv_val = -1; o_ov_cnt = 0; o_same = 1'b0;
        @(negedge clk);
        cfg_two_octet     = two[0];
        cfg_len_offset    = off[3:0];
        cfg_len_width     = wid[3:0];
        cfg_len_msb_first = msb[0];
        rx_start = 1'b1;
        rx_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            observe();
            rx_start = 1'b0;
            if (gaps != 0 && (i % 4) == 3) begin
                rx_valid = 1'b0;
                rx_bit   = ~rx_bit;
                @(negedge clk);
                observe();
            end
            rx_valid = 1'b1;
            rx_bit   = exp_bits[i];
        end
        @(negedge clk);
        observe();
        rx_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            observe();
        end
        chk("R3", "cfg_error", int'(cfg_error), int'(!ok));
        chk("R2 R3", "len_valid pulses", o_lv_cnt, int'(ok));
        if (ok) begin
            chk("R2", "len_value at pulse", o_lv_val, fv);
            chk("R2", "len_value held", int'(len_value), fv);
        end
        chk("R7", "oversize pulses", o_ov_cnt, int'(over));
        chk("R4 R5", "forwarded bit count", o_crc_cnt, span);
        chk("R5 R8", "forwarded bit mismatches", o_crc_bad, 0);
        chk("R6 R7", "frame_end pulses", o_fe_cnt, int'(ok && !over));
        if (ok && !over) chk("R6", "frame_end position", o_fe_at, span);
        chk("R6", "len_valid with frame_end", int'(o_same), int'(same));
    endtask

    task automatic rx_partial(input int nb);
        @(negedge clk);
        cfg_two_octet = 1'b1; cfg_len_offset = 4'd3; cfg_len_width = 4'd6; cfg_len_msb_first = 1'b1;
        rx_start = 1'b1;
        rx_valid = 1'b0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rx_start = 1'b0;
            rx_valid = 1'b1;
            rx_bit   = 1'b1;
        end
    endtask

    task automatic tx_run(input int auto, input int len);
        int  hidx;
        bit  st;
        hidx = 0;
        @(negedge clk);
        tx_start = 1'b1; tx_auto_hdr = auto[0]; tx_len = len[7:0];
        tx_step = 1'b1; tx_buf_bit = 1'b0;
        #1;
        chk("R10", "pop in start cycle", int'(tx_buf_pop), 0);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            tx_start   = 1'b0;
            st         = (c % 3) != 2;
            tx_step    = st;
            tx_buf_bit = ((c + len) % 2) == 1;
            #1;
            if (auto != 0 && hidx < 8) begin
                chk("R9", "header bit", int'(tx_bit), (len >> hidx) & 1);
                chk("R9", "pop during header", int'(tx_buf_pop), 0);
                if (st) hidx++;
            end else begin
                chk(auto != 0 ? "R9" : "R10", "buffer bit", int'(tx_bit), int'(tx_buf_bit));
                chk(auto != 0 ? "R9" : "R10", "pop follows step", int'(tx_buf_pop), int'(st));
            end
        end
        @(negedge clk);
        tx_step = 1'b0;
    endtask

    initial begin
        int len;
        rst = 1'b1;
        rx_start = 0; rx_valid = 0; rx_bit = 0;
        cfg_two_octet = 0; cfg_len_offset = 0; cfg_len_width = 0; cfg_len_msb_first = 0;
        tx_start = 0; tx_auto_hdr = 0; tx_len = 0; tx_step = 0; tx_buf_bit = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "len_valid", int'(len_valid), 0);
        chk("R1", "len_value", int'(len_value), 0);
        chk("R1", "crc_valid", int'(crc_valid), 0);
        chk("R1", "frame_end", int'(frame_end), 0);
        chk("R1", "oversize_error", int'(oversize_error), 0);
        chk("R1", "tx_buf_pop", int'(tx_buf_pop), 0);

        for (int two = 0; two < 2; two++)
            for (int off = 0; off < 16; off++)
                for (int wid = 0; wid < 16; wid++)
                    for (int msb = 0; msb < 2; msb++) begin
                        if (wid >= 1 && wid <= 9 && off + wid == (two ? 16 : 8) && msb == 0)
                            len = 0;
                        else
                            len = (off + wid + msb) % 6;
                        if (wid >= 1 && wid <= 9) len = len % (1 << wid);
                        rx_frame(two, off, wid, msb, len, 5, int'((off + wid) % 3 == 0));
                    end

        // R8: restart in the middle of a frame
        rx_partial(5);
        rx_frame(1, 4, 9, 1, 3, 4, 0);
        rx_partial(20);
        rx_frame(0, 2, 5, 0, 4, 3, 1);

        // R7: boundaries of the frame size limit
        rx_frame(1, 7, 9, 1, 509, 2, 0);
        rx_frame(1, 7, 9, 0, 510, 2, 0);
        rx_frame(1, 0, 9, 1, 511, 2, 0);

        for (int a = 0; a < 2; a++)
            for (int l = 0; l < 256; l++)
                tx_run(a, l);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule